// File: doc/BRIEF.md
# Packed BCD Add-with-Extend Unit

This block performs one decimal addition step per cycle for a multi-byte packed-BCD chain. Each cycle it can accept a 16-bit opcode word, a source byte and a destination byte, each byte holding two decimal digits. It checks that the opcode is the add-decimal-with-extend encoding and decodes it. One cycle later it presents the decimal sum of destination, source and the extend flag, and it updates its own five-bit condition-code register.

The unit also reports which operand form the opcode asked for and passes the two register fields on. Address generation, memory traffic and the register file belong to the surrounding datapath. A separate load port lets software preset the condition codes. The usual case is to set Z before a chain, because the operation can only clear Z, so after the last byte Z shows whether the whole multi-byte result was zero.

Top module: `pbcd_addx_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0 and ccr is 5'b00000.
- R2: Every cycle with in_valid high gives exactly one cycle of out_valid high on the next cycle. A cycle with in_valid low gives out_valid low on the next cycle.
- R3: For a legal opcode, out_sum is the two-digit packed BCD value of (dst + src + X) mod 100. The high nibble holds the tens digit and the low nibble the units digit. X is ccr bit 4 as it stands in the input cycle.
- R4: The ccr bits are {X,N,Z,V,C} at bits 4..0. After a legal operation, C is 1 exactly when dst + src + X is 100 or more, and X is written with the same value as C.
- R5: After a legal operation, Z is cleared when out_sum is nonzero and keeps its previous value when out_sum is zero. An operation never sets Z.
- R6: After a legal operation, N equals out_sum bit 7 and V is 0.
- R7: An opcode is legal only when bits 15..12 are 4'b1100 and bits 8..4 are 5'b10000. Any other opcode gives out_illegal = 1 and out_sum = 0, and it leaves ccr unchanged.
- R8: out_mem_form equals opcode bit 3 (1 = predecrement memory form, 0 = data-register form). out_reg_hi equals opcode bits 11..9 and out_reg_lo equals opcode bits 2..0.
- R9: ccr_load high writes ccr_load_val into ccr at the next edge. It takes precedence over the flag update of an operation issued in the same cycle.
- R10: In back-to-back operations, the X written by one operation is the carry-in of the operation issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_opcode | input | 16 | Instruction word |
| in_src | input | 8 | Source packed-BCD byte |
| in_dst | input | 8 | Destination packed-BCD byte |
| ccr_load | input | 1 | Preset condition codes |
| ccr_load_val | input | 5 | Value for preset, {X,N,Z,V,C} |
| out_valid | output | 1 | Result strobe |
| out_sum | output | 8 | Packed-BCD sum |
| out_illegal | output | 1 | Opcode did not match the encoding |
| out_mem_form | output | 1 | Predecrement memory form requested |
| out_reg_hi | output | 3 | Register field, opcode bits 11..9 |
| out_reg_lo | output | 3 | Register field, opcode bits 2..0 |
| ccr | output | 5 | Condition codes {X,N,Z,V,C} |

## Verification
The assertions check on every cycle that the output strobe follows the input strobe by one cycle and that X matches C after each legal operation. They also check that V stays 0, that Z is never raised by an operation and drops on a nonzero sum, that sum digits stay decimal, and that an illegal opcode freezes the condition codes. The exact decimal sums and carries only show up in the bench's scenarios. These cover digit carries at 9+1 and at 99+1, extend chaining across back-to-back bytes, the sticky-zero chain outcome, the load-versus-operation collision, and field passing for both operand forms.

// File: rtl/pbcd_pkg.sv
package pbcd_pkg;
  localparam int OP_W = 16;
  localparam int DIGIT_W = 4;
  localparam int RF_W = 3;
  localparam logic [3:0] OP_TOP = 4'b1100;
  localparam logic [4:0] OP_MID = 5'b10000;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/pbcd_decode.sv
module pbcd_decode
  import pbcd_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output logic            legal,
  output logic            mem_form,
  output logic [RF_W-1:0] reg_hi,
  output logic [RF_W-1:0] reg_lo
);
  always_comb begin
    legal    = (opcode[15:12] == OP_TOP) && (opcode[8:4] == OP_MID);
    mem_form = opcode[3];
    reg_hi   = opcode[11:9];
    reg_lo   = opcode[2:0];
  end
endmodule

// File: rtl/pbcd_digit_add.sv
module pbcd_digit_add
  import pbcd_pkg::*;
(
  input  logic [DIGIT_W-1:0] a,
  input  logic [DIGIT_W-1:0] b,
  input  logic               cin,
  output logic [DIGIT_W-1:0] s,
  output logic               cout
);
  logic [DIGIT_W:0] raw;
  logic             fix;
  always_comb begin
    raw  = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
    fix  = raw > (DIGIT_W+1)'(9);
    s    = fix ? (raw[DIGIT_W-1:0] + DIGIT_W'(6)) : raw[DIGIT_W-1:0];
    cout = fix;
  end
endmodule

// File: rtl/pbcd_adder.sv
module pbcd_adder
  import pbcd_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
)(
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [DIGITS:0] chain;
  assign chain[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    pbcd_digit_add u_dig (
      .a    (a[g*DIGIT_W +: DIGIT_W]),
      .b    (b[g*DIGIT_W +: DIGIT_W]),
      .cin  (chain[g]),
      .s    (sum[g*DIGIT_W +: DIGIT_W]),
      .cout (chain[g+1])
    );
  end

  assign cout = chain[DIGITS];
endmodule

// File: rtl/pbcd_flags.sv
module pbcd_flags
  import pbcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  ccr_t load_val,
  input  logic upd,
  input  logic carry,
  input  logic res_zero,
  input  logic res_msb,
  output ccr_t ccr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_q <= '0;
    end else if (load) begin
      ccr_q <= load_val;
    end else if (upd) begin
      ccr_q.c <= carry;
      ccr_q.x <= carry;
      ccr_q.z <= ccr_q.z & res_zero;
      ccr_q.n <= res_msb;
      ccr_q.v <= 1'b0;
    end
  end

  // R5: an update never raises Z
  a_r5_z_never_set: assert property (@(posedge clk) disable iff (rst)
    (upd && !load && !ccr_q.z) |=> !ccr_q.z);
endmodule

// File: rtl/pbcd_addx_unit.sv
module pbcd_addx_unit
  import pbcd_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_opcode,
  input  logic [W-1:0]    in_src,
  input  logic [W-1:0]    in_dst,
  input  logic            ccr_load,
  input  logic [4:0]      ccr_load_val,
  output logic            out_valid,
  output logic [W-1:0]    out_sum,
  output logic            out_illegal,
  output logic            out_mem_form,
  output logic [RF_W-1:0] out_reg_hi,
  output logic [RF_W-1:0] out_reg_lo,
  output logic [4:0]      ccr
);
  logic            legal, mem_form;
  logic [RF_W-1:0] reg_hi, reg_lo;
  logic [W-1:0]    sum_c;
  logic            cout_c;
  ccr_t            ccr_q;

  pbcd_decode u_dec (
    .opcode   (in_opcode),
    .legal    (legal),
    .mem_form (mem_form),
    .reg_hi   (reg_hi),
    .reg_lo   (reg_lo)
  );

  pbcd_adder #(.DIGITS(DIGITS)) u_add (
    .a    (in_dst),
    .b    (in_src),
    .cin  (ccr_q.x),
    .sum  (sum_c),
    .cout (cout_c)
  );

  pbcd_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .load     (ccr_load),
    .load_val (ccr_t'(ccr_load_val)),
    .upd      (in_valid && legal),
    .carry    (cout_c),
    .res_zero (sum_c == '0),
    .res_msb  (sum_c[W-1]),
    .ccr_q    (ccr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_sum      <= '0;
      out_illegal  <= 1'b0;
      out_mem_form <= 1'b0;
      out_reg_hi   <= '0;
      out_reg_lo   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum      <= legal ? sum_c : '0;
        out_illegal  <= !legal;
        out_mem_form <= mem_form;
        out_reg_hi   <= reg_hi;
        out_reg_lo   <= reg_lo;
      end
    end
  end

  assign ccr = ccr_q;

  // R2: one result per accepted operation
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4: extend mirrors carry after a legal operation
  a_r4_x_eq_c: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && !ccr_load) |=> (ccr[4] == ccr[0]));
  // R6: overflow flag written as zero
  a_r6_v_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && !ccr_load) |=> !ccr[1]);
  // R5: nonzero result clears Z
  a_r5_z_cleared: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && !ccr_load) |=> (out_sum == '0 || !ccr[2]));
  // R7: illegal opcode keeps condition codes
  a_r7_illegal_keeps_ccr: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal && !ccr_load) |=> $stable(ccr));
  // R3: decimal digits in, decimal digits out
  a_r3_digits_decimal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && in_src[3:0] < 4'd10 && in_src[7:4] < 4'd10
     && in_dst[3:0] < 4'd10 && in_dst[7:4] < 4'd10)
    |=> (out_sum[3:0] < 4'd10 && out_sum[7:4] < 4'd10));
endmodule

// File: tb/pbcd_addx_unit_tb.sv
module pbcd_addx_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_opcode = '0;
  logic [7:0]  in_src = '0, in_dst = '0;
  logic        ccr_load = 1'b0;
  logic [4:0]  ccr_load_val = '0;
  logic        out_valid, out_illegal, out_mem_form;
  logic [7:0]  out_sum;
  logic [2:0]  out_reg_hi, out_reg_lo;
  logic [4:0]  ccr;

  int checks = 0, fails = 0;
  logic [4:0] m_ccr = '0;

  typedef struct {
    logic [7:0] sum;
    logic       ill;
    logic       mem;
    logic [2:0] hi;
    logic [2:0] lo;
    logic [4:0] ccr;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pbcd_addx_unit dut_i (
    .clk, .rst, .in_valid, .in_opcode, .in_src, .in_dst, .ccr_load,
    .ccr_load_val, .out_valid, .out_sum, .out_illegal, .out_mem_form,
    .out_reg_hi, .out_reg_lo, .ccr
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dval(logic [7:0] b);
    return b[7:4] * 10 + b[3:0];
  endfunction

  // drive one operation (and optionally a same-cycle preset), push expectation
  task automatic issue(logic [15:0] op, logic [7:0] s, logic [7:0] d,
                       logic ld, logic [4:0] ldv, string tag);
    exp_t e;
    logic legal;
    int tot, r;
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_src = s; in_dst = d;
    ccr_load = ld; ccr_load_val = ldv;
    legal = (op[15:12] == 4'hC) && (op[8:4] == 5'b10000);
    e.ill = !legal; e.mem = op[3]; e.hi = op[11:9]; e.lo = op[2:0]; e.tag = tag;
    if (legal) begin
      tot = dval(d) + dval(s) + int'(m_ccr[4]);
      r = tot % 100;
      e.sum = {4'(r / 10), 4'(r % 10)};
      if (!ld) begin
        m_ccr[0] = (tot >= 100);
        m_ccr[4] = (tot >= 100);
        m_ccr[2] = m_ccr[2] && (r == 0);
        m_ccr[3] = e.sum[7];
        m_ccr[1] = 1'b0;
      end
    end else begin
      e.sum = 8'h00;
    end
    if (ld) m_ccr = ldv;
    e.ccr = m_ccr;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; ccr_load = 1'b0;
  endtask

  task automatic preset(logic [4:0] v);
    @(negedge clk);
    in_valid = 1'b0; ccr_load = 1'b1; ccr_load_val = v;
    m_ccr = v;
    @(negedge clk);
    ccr_load = 1'b0;
    chk("R9 preset ccr", 32'(ccr), 32'(v));
  endtask

  function automatic logic [15:0] mk(logic [2:0] hi, logic rm, logic [2:0] lo);
    return 16'hC100 | (16'(hi) << 9) | (16'(rm) << 3) | 16'(lo);
  endfunction

  // monitor: compare each result against the scoreboard head
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          chk("R2 unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " R3 sum"}, 32'(out_sum), 32'(e.sum));
          chk({e.tag, " R7 illegal"}, 32'(out_illegal), 32'(e.ill));
          chk({e.tag, " R8 fields"}, {25'd0, out_mem_form, out_reg_hi, out_reg_lo},
              {25'd0, e.mem, e.hi, e.lo});
          chk({e.tag, " R4 R5 R6 ccr"}, 32'(ccr), 32'(e.ccr));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid in reset", 32'(out_valid), 0);
    chk("R1 ccr in reset", 32'(ccr), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 out_valid after reset", 32'(out_valid), 0);
    chk("R1 ccr after reset", 32'(ccr), 0);

    // R3 simple, no carries
    issue(mk(3'd1, 1'b0, 3'd2), 8'h12, 8'h34, 0, 0, "R3 plain");
    // R3 low digit carry 9+1
    issue(mk(3'd7, 1'b1, 3'd5), 8'h09, 8'h01, 0, 0, "R3 digit carry");
    idle();
    // R2 idle gap gives no output
    @(posedge clk); #1;
    chk("R2 no result when idle", 32'(out_valid), 0);

    // R10 chain: 99+01 carries, next byte absorbs X; R5 sticky Z preset
    preset(5'b00100);
    issue(mk(3'd0, 1'b1, 3'd0), 8'h01, 8'h99, 0, 0, "R10 chain b0");
    issue(mk(3'd0, 1'b1, 3'd0), 8'h00, 8'h00, 0, 0, "R10 chain b1");
    idle();

    // R5 zero-result chain keeps Z set
    preset(5'b00100);
    issue(mk(3'd2, 1'b0, 3'd3), 8'h50, 8'h50, 0, 0, "R5 zero keeps Z");
    issue(mk(3'd2, 1'b0, 3'd3), 8'h49, 8'h50, 0, 0, "R5 99 with X");
    // R6 large result sets N
    issue(mk(3'd4, 1'b0, 3'd6), 8'h45, 8'h42, 0, 0, "R6 N from msb");
    idle();

    // R7 illegal encodings keep ccr
    preset(5'b10101);
    issue(16'hD100, 8'h11, 8'h22, 0, 0, "R7 wrong top");
    issue(16'hC110, 8'h11, 8'h22, 0, 0, "R7 wrong mid");
    // R4 X=1 carried in from preset then cleared
    issue(mk(3'd5, 1'b1, 3'd1), 8'h00, 8'h00, 0, 0, "R4 X in");
    idle();

    // R9 load collides with operation: load wins
    preset(5'b10000);
    issue(mk(3'd6, 1'b0, 3'd7), 8'h88, 8'h77, 1, 5'b01010, "R9 collision");
    idle();
    @(negedge clk);
    chk("R9 ccr after collision", 32'(ccr), 32'(5'b01010));

    // R3 sweep of assorted bytes
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a, b;
      a = {4'((i * 7) % 10), 4'((i * 3) % 10)};
      b = {4'((i * 5 + 2) % 10), 4'((i + 9) % 10)};
      issue(mk(3'(i), 1'(i), 3'(i + 3)), a, b, 0, 0, "R3 sweep");
    end
    idle();
    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 32'(sb.size()), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule